// File: doc/BRIEF.md
# Interrupt gate descriptor fetch unit

This unit turns an 8-bit interrupt vector into a checked handler target. A request carries the vector, a tag that says where the event came from (hardware line, processor exception or software instruction) and the privilege level of the code that was running. The unit first compares the selected entry against the table limit. It then reads the 8-byte gate descriptor as two 32-bit words over a request/acknowledge memory port and decodes it. The result is either a completion pulse with a code selector, a 32-bit handler offset, a clear-interrupt-flag bit and a task-switch bit, or a fault pulse with a fault code.

The table base address and byte limit sit in a register pair that is loaded through a strobe. A load is accepted only while no fetch is in progress. Stack switching, frame pushing, segment lookup and the task switch itself belong to the surrounding logic. This unit only reports what the gate asks for.

Top module: `gate_fetch_unit`

## Requirements
- R1: The low word of a descriptor is read first from address base + vector*8, then the high word from that address + 4. Each read is one cycle with `mem_req` high and `mem_ack` high.
- R2: When vector*8 + 7 is greater than the limit, the unit reports a fault with code 1 (general protection) one cycle after the start and issues no memory request. A limit of 8N-1 admits vectors 0 to N-1.
- R3: Gate type, in descriptor bits 43:40, is decoded as follows: 14 is an interrupt gate, 15 a trap gate, 5 a task gate. Any other type gives fault code 1.
- R4: For interrupt and trap gates, a nonzero value in descriptor bits 39:32 or bit 44 gives fault code 1. A task gate ignores those bits.
- R5: When the source tag is 2 (software) and the current privilege level is numerically greater than the gate's privilege field (bits 46:45), the unit reports fault code 1. Tags 0 (hardware), 1 (exception) and 3 skip this check.
- R6: When present bit 47 is clear, the unit reports fault code 2 (not present).
- R7: Checks are applied in this order: limit, then type and reserved bits, then privilege, then present. Only the first check that fails is reported.
- R8: On success, `done` pulses for one cycle with `fault_code` 0. `handler_sel` is bits 31:16 and `handler_off` is {bits 63:48, bits 15:0}. `done` and `fault` are never high together, and a fault clears all result fields to 0.
- R9: `clear_if` is 1 for an interrupt gate and 0 for a trap gate. `task_switch` is 1 only for a task gate, which also reports `handler_off` as 0.
- R10: `busy` is high from the cycle after an accepted start until the result pulse. A start while busy is ignored.
- R11: A table load while busy is ignored. A load while idle is used by the next start.
- R12: After reset, `busy`, `done`, `fault` and `mem_req` are low and the table base and limit are 0, so any vector faults on the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_load | input | 1 | Load strobe for table base and limit |
| tbl_base | input | ADDR_W | Table base address to load |
| tbl_limit | input | LIMIT_W | Table byte limit to load |
| start | input | 1 | Start a fetch (taken only when not busy) |
| vector | input | VEC_W | Interrupt vector |
| src | input | 2 | Source tag: 0 hardware, 1 exception, 2 software |
| cpl | input | 2 | Current privilege level |
| busy | output | 1 | Fetch in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Read accepted, data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Success pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 0 none, 1 general protection, 2 not present |
| handler_sel | output | 16 | Code or task selector |
| handler_off | output | 32 | Handler offset |
| clear_if | output | 1 | Handler entry clears the interrupt flag |
| task_switch | output | 1 | Gate asks for a task switch |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high, and for one cycle per word. They also assume that `start` is a one-cycle strobe driven with stable vector, source and privilege inputs. The bench's memory model answers only a pending request, after a programmable wait, and drops the acknowledge on the next cycle. All inputs change on the falling clock edge, so the rising-edge properties see settled values. Stimulus sweeps every vector, every gate type, every reserved-bit position and every source/privilege/DPL combination. The model never answers with data for an address outside the table.

// File: rtl/gate_fetch_pkg.sv
package gate_fetch_pkg;

   typedef enum logic [1:0] {
      SRC_HW  = 2'd0,
      SRC_EXC = 2'd1,
      SRC_SW  = 2'd2,
      SRC_RSV = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_NP   = 2'd2
   } flt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2
   } st_e;

   localparam logic [3:0] GT_TASK = 4'd5;
   localparam logic [3:0] GT_INTR = 4'd14;
   localparam logic [3:0] GT_TRAP = 4'd15;

   typedef struct packed {
      logic [15:0] sel;
      logic [31:0] off;
      logic        clr_if;
      logic        task_sw;
      flt_e        flt;
   } gate_res_t;

endpackage

// File: rtl/gate_table_reg.sv
module gate_table_reg #(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               load,
   input  logic [ADDR_W-1:0]  base_in,
   input  logic [LIMIT_W-1:0] limit_in,
   output logic [ADDR_W-1:0]  base_q,
   output logic [LIMIT_W-1:0] limit_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (load && !hold) begin
         base_q  <= base_in;
         limit_q <= limit_in;
      end
   end

endmodule

// File: rtl/gate_bound_check.sv
module gate_bound_check #(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 16,
   parameter int VEC_W   = 8
) (
   input  logic [VEC_W-1:0]   vec,
   input  logic [ADDR_W-1:0]  base,
   input  logic [LIMIT_W-1:0] limit,
   output logic [ADDR_W-1:0]  entry_addr,
   output logic               over
);

   localparam int SPAN_W = VEC_W + 3;
   localparam int CMP_W  = (SPAN_W > LIMIT_W) ? SPAN_W : LIMIT_W;

   logic [CMP_W-1:0] last_byte;
   logic [CMP_W-1:0] limit_x;

   assign last_byte  = CMP_W'({vec, 3'b111});
   assign limit_x    = CMP_W'(limit);
   assign over       = last_byte > limit_x;
   assign entry_addr = base + ADDR_W'({vec, 3'b000});

endmodule

// File: rtl/gate_decode.sv
module gate_decode
   import gate_fetch_pkg::*;
(
   input  logic [31:0] lo_word,
   input  logic [31:0] hi_word,
   input  logic [1:0]  src,
   input  logic [1:0]  cpl,
   output gate_res_t   res
);

   logic [3:0] gtype;
   logic [1:0] dpl;
   logic       present;
   logic       rsv_bad;
   logic       is_intr, is_trap, is_task;

   assign gtype   = hi_word[11:8];
   assign dpl     = hi_word[14:13];
   assign present = hi_word[15];
   assign rsv_bad = (hi_word[7:0] != 8'd0) || hi_word[12];
   assign is_intr = gtype == GT_INTR;
   assign is_trap = gtype == GT_TRAP;
   assign is_task = gtype == GT_TASK;

   always_comb begin
      res = '0;
      res.flt = FLT_NONE;
      if (!(is_intr || is_trap || is_task) || ((is_intr || is_trap) && rsv_bad)) begin
         res.flt = FLT_GP;
      end else if ((src == SRC_SW) && (cpl > dpl)) begin
         res.flt = FLT_GP;
      end else if (!present) begin
         res.flt = FLT_NP;
      end else begin
         res.sel     = lo_word[31:16];
         res.off     = is_task ? 32'd0 : {hi_word[31:16], lo_word[15:0]};
         res.clr_if  = is_intr;
         res.task_sw = is_task;
      end
   end

endmodule

// File: rtl/gate_fetch_unit.sv
module gate_fetch_unit
   import gate_fetch_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 16,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_load,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [LIMIT_W-1:0] tbl_limit,
   input  logic               start,
   input  logic [VEC_W-1:0]   vector,
   input  logic [1:0]         src,
   input  logic [1:0]         cpl,
   output logic               busy,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata,
   output logic               done,
   output logic               fault,
   output logic [1:0]         fault_code,
   output logic [15:0]        handler_sel,
   output logic [31:0]        handler_off,
   output logic               clear_if,
   output logic               task_switch
);

   if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec_w
      $error("VEC_W must be 1..8");
   end
   if (ADDR_W < VEC_W + 3) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the table span");
   end
   if (LIMIT_W < 3) begin : g_bad_limit_w
      $error("LIMIT_W must be at least 3");
   end

   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(4);

   st_e                st_q;
   logic [ADDR_W-1:0]  tbl_base_q;
   logic [LIMIT_W-1:0] tbl_limit_q;
   logic [ADDR_W-1:0]  entry_addr, addr_q;
   logic               over;
   logic [31:0]        lo_q;
   logic [1:0]         src_q, cpl_q;
   gate_res_t          res;
   logic               accept;

   gate_table_reg #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .hold(busy), .load(tbl_load),
      .base_in(tbl_base), .limit_in(tbl_limit),
      .base_q(tbl_base_q), .limit_q(tbl_limit_q)
   );

   gate_bound_check #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W)) u_bound (
      .vec(vector), .base(tbl_base_q), .limit(tbl_limit_q),
      .entry_addr(entry_addr), .over(over)
   );

   gate_decode u_dec (
      .lo_word(lo_q), .hi_word(mem_rdata), .src(src_q), .cpl(cpl_q), .res(res)
   );

   assign busy     = st_q != ST_IDLE;
   assign mem_req  = busy;
   assign mem_addr = (st_q == ST_HI) ? addr_q + HI_STEP : addr_q;
   assign accept   = (st_q == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         addr_q      <= '0;
         lo_q        <= '0;
         src_q       <= '0;
         cpl_q       <= '0;
         done        <= 1'b0;
         fault       <= 1'b0;
         fault_code  <= '0;
         handler_sel <= '0;
         handler_off <= '0;
         clear_if    <= 1'b0;
         task_switch <= 1'b0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  src_q  <= src;
                  cpl_q  <= cpl;
                  addr_q <= entry_addr;
                  if (over) begin
                     fault       <= 1'b1;
                     fault_code  <= FLT_GP;
                     handler_sel <= '0;
                     handler_off <= '0;
                     clear_if    <= 1'b0;
                     task_switch <= 1'b0;
                  end else begin
                     st_q <= ST_LO;
                  end
               end
            end
            ST_LO: begin
               if (mem_ack) begin
                  lo_q <= mem_rdata;
                  st_q <= ST_HI;
               end
            end
            ST_HI: begin
               if (mem_ack) begin
                  st_q        <= ST_IDLE;
                  done        <= res.flt == FLT_NONE;
                  fault       <= res.flt != FLT_NONE;
                  fault_code  <= res.flt;
                  handler_sel <= res.sel;
                  handler_off <= res.off;
                  clear_if    <= res.clr_if;
                  task_switch <= res.task_sw;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R8
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_ack && mem_req));

   // R2
   limit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && over) |=> (!mem_req && fault && fault_code == FLT_GP));

   // R9
   gate_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(clear_if && task_switch));

   // R10
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R11
   tbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(tbl_limit_q) && $stable(tbl_base_q)));

endmodule

// File: tb/tb_gate_fetch_unit.sv
module tb_gate_fetch_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE0 = 32'h0000_2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_load = 1'b0;
   logic [31:0] tbl_base = '0;
   logic [15:0] tbl_limit = '0;
   logic        start = 1'b0;
   logic [7:0]  vector = '0;
   logic [1:0]  src = '0;
   logic [1:0]  cpl = '0;
   logic        busy, mem_req, done, fault, clear_if, task_switch;
   logic [31:0] mem_addr, handler_off;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  fault_code;
   logic [15:0] handler_sel;

   int n_chk = 0;
   int n_fail = 0;
   int lat = 0;
   int wcnt = 0;
   int reads = 0;
   logic [31:0] addr0, addr1;
   logic [31:0] model_base = '0;
   logic [15:0] model_limit = '0;
   logic [63:0] desc_tbl [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_fetch_unit dut (
      .clk(clk), .rst_n(rst_n), .tbl_load(tbl_load), .tbl_base(tbl_base),
      .tbl_limit(tbl_limit), .start(start), .vector(vector), .src(src), .cpl(cpl),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .done(done), .fault(fault), .fault_code(fault_code),
      .handler_sel(handler_sel), .handler_off(handler_off), .clear_if(clear_if),
      .task_switch(task_switch)
   );

   function automatic logic [31:0] fetch_word(input logic [31:0] a);
      logic [31:0] d;
      d = a - model_base;
      if (d > 32'd2047) return 32'hDEAD_BEEF;
      return d[2] ? desc_tbl[d[10:3]][63:32] : desc_tbl[d[10:3]][31:0];
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = fetch_word(mem_addr);
            if (reads == 0) addr0 = mem_addr; else addr1 = mem_addr;
            reads++;
         end else begin
            wcnt++;
         end
      end else begin
         wcnt = 0;
      end
   end

   function automatic logic [63:0] mk(input logic [31:0] off, input logic [15:0] sel,
                                      input logic [3:0] t, input logic [1:0] dpl,
                                      input logic p, input logic [7:0] rsv, input logic b44);
      return {off[31:16], p, dpl, b44, t, rsv, sel, off[15:0]};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic load_tbl(input logic [31:0] b, input logic [15:0] l);
      @(negedge clk);
      tbl_load = 1'b1; tbl_base = b; tbl_limit = l;
      @(negedge clk);
      tbl_load = 1'b0;
      model_base = b; model_limit = l;
   endtask

   // expected outcome from the requirements: {code, sel, off, clear_if, task}
   function automatic logic [51:0] expect_of(input logic [7:0] v, input logic [1:0] s,
                                             input logic [1:0] c, output int nreads);
      logic [63:0] d;
      logic [3:0] t;
      logic ok_t, rsv;
      d = desc_tbl[v];
      if ({5'd0, v, 3'b111} > {3'd0, model_limit}) begin
         nreads = 0;
         return {2'd1, 50'd0};
      end
      nreads = 2;
      t = d[43:40];
      ok_t = (t == 4'd14) || (t == 4'd15) || (t == 4'd5);
      rsv = (t != 4'd5) && ((d[39:32] != 0) || d[44]);
      if (!ok_t || rsv) return {2'd1, 50'd0};
      if (s == 2'd2 && c > d[46:45]) return {2'd1, 50'd0};
      if (!d[47]) return {2'd2, 50'd0};
      return {2'd0, d[31:16], (t == 4'd5) ? 32'd0 : {d[63:48], d[15:0]},
              t == 4'd14, t == 4'd5};
   endfunction

   task automatic wait_result(input string rq, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (done || fault) begin ok = 1'b1; break; end
      end
      if (!ok) chk(1'b0, rq, "timeout", 0, 1);
   endtask

   task automatic run_case(input logic [7:0] v, input logic [1:0] s,
                           input logic [1:0] c, input string rq);
      logic [51:0] exp;
      int nreads;
      bit got;
      exp = expect_of(v, s, c, nreads);
      reads = 0;
      @(negedge clk);
      start = 1'b1; vector = v; src = s; cpl = c;
      @(negedge clk);
      start = 1'b0;
      if (done || fault) got = 1'b1;
      else wait_result(rq, got);
      if (got) begin
         chk({fault_code, handler_sel, handler_off, clear_if, task_switch} == exp,
             rq, "result", 64'({fault_code, handler_sel, handler_off, clear_if, task_switch}),
             64'(exp));
         chk((done == (exp[51:50] == 0)) && (fault == (exp[51:50] != 0)), rq,
             "done/fault", {done, fault}, {exp[51:50] == 0, exp[51:50] != 0});
         chk(reads == nreads, "R2 R1", "read count", reads, nreads);
         if (nreads == 2)
            chk(addr0 == model_base + {21'd0, v, 3'd0} && addr1 == addr0 + 4, "R1",
                "addresses", {addr0, addr1}, {model_base + {21'd0, v, 3'd0},
                model_base + {21'd0, v, 3'd0} + 32'd4});
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++)
         desc_tbl[i] = mk({i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'h11}, {8'h08, i[7:0]},
                          (i % 4 == 1) ? 4'd15 : (i % 4 == 2) ? 4'd5 : 4'd14,
                          2'd3, 1'b1, 8'd0, 1'b0);
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!busy && !done && !fault && !mem_req, "R12", "reset outputs",
          {busy, done, fault, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset limit 0: vector 0 faults, no reads
      run_case(8'd0, 2'd0, 2'd0, "R12");

      load_tbl(BASE0, 16'd511);
      // R2 R8 R9 sweep of all vectors; 63 is last inside, 64 first outside
      for (int v = 0; v < 256; v++) run_case(v[7:0], 2'd0, 2'd3, "R2 R8 R9");

      // R3 type sweep
      for (int t = 0; t < 16; t++) begin
         desc_tbl[10] = mk(32'hCAFE_1234, 16'h0010, t[3:0], 2'd0, 1'b1, 8'd0, 1'b0);
         run_case(8'd10, 2'd1, 2'd0, "R3");
      end

      // R4 reserved bits per position and gate type
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 9; b++) begin
            desc_tbl[11] = mk(32'h0BAD_F00D, 16'h0018,
                              (g == 0) ? 4'd14 : (g == 1) ? 4'd15 : 4'd5, 2'd3, 1'b1,
                              (b < 8) ? 8'(1 << b) : 8'd0, b == 8);
            run_case(8'd11, 2'd2, 2'd3, "R4");
         end

      // R5 privilege over source, cpl, dpl
      lat = 1;
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++) begin
               desc_tbl[20] = mk(32'h1357_9BDF, 16'h0020, 4'd14, d[1:0], 1'b1, 8'd0, 1'b0);
               run_case(8'd20, s[1:0], c[1:0], "R5");
            end

      // R6 not present, all gate kinds
      lat = 3;
      for (int g = 0; g < 3; g++) begin
         desc_tbl[30] = mk(32'h2468_ACE0, 16'h0028,
                           (g == 0) ? 4'd14 : (g == 1) ? 4'd15 : 4'd5, 2'd3, 1'b0, 8'd0, 1'b0);
         run_case(8'd30, 2'd0, 2'd0, "R6");
      end

      // R7 fault ordering: bad type / privilege fail / not present combinations
      lat = 0;
      for (int k = 0; k < 8; k++) begin
         desc_tbl[40] = mk(32'h0F0F_F0F0, 16'h0030, k[0] ? 4'd3 : 4'd15,
                           k[1] ? 2'd0 : 2'd3, !k[2], 8'd0, 1'b0);
         run_case(8'd40, 2'd2, 2'd3, "R7");
      end
      desc_tbl[41] = mk(32'h0, 16'h0, 4'd14, 2'd0, 1'b0, 8'h80, 1'b0);
      run_case(8'd41, 2'd2, 2'd3, "R7");

      // R10 busy timing and ignored start while busy
      lat = 5;
      reads = 0;
      @(negedge clk);
      start = 1'b1; vector = 8'd3; src = 2'd0; cpl = 2'd0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      @(negedge clk);
      start = 1'b1; vector = 8'd4;
      @(negedge clk);
      start = 1'b0;
      begin
         bit got;
         wait_result("R10", got);
         if (got) begin
            chk(done && handler_sel == {8'h08, 8'd3}, "R10", "first request kept",
                {done, handler_sel}, {1'b1, 8'h08, 8'd3});
            chk(reads == 2, "R10", "only one fetch", reads, 2);
            @(negedge clk);
            chk(!busy && !done && !mem_req, "R10", "idle after result",
                {busy, done, mem_req}, 0);
         end
      end

      // R11 load while busy ignored
      reads = 0;
      @(negedge clk);
      start = 1'b1; vector = 8'd5; src = 2'd0; cpl = 2'd0;
      @(negedge clk);
      start = 1'b0;
      tbl_load = 1'b1; tbl_base = 32'h0000_9000; tbl_limit = 16'd7;
      @(negedge clk);
      tbl_load = 1'b0;
      begin
         bit got;
         wait_result("R11", got);
      end
      lat = 0;
      run_case(8'd40, 2'd0, 2'd0, "R11");
      chk(addr0 == BASE0 + 32'd320, "R11", "old base kept", addr0, BASE0 + 32'd320);
      // R11 idle load takes effect
      desc_tbl[1] = mk(32'h7777_8888, 16'h0040, 4'd15, 2'd0, 1'b1, 8'd0, 1'b0);
      desc_tbl[0] = mk(32'h1111_2222, 16'h0048, 4'd14, 2'd0, 1'b1, 8'd0, 1'b0);
      load_tbl(32'h0000_9000, 16'd15);
      run_case(8'd1, 2'd0, 2'd0, "R11");
      run_case(8'd2, 2'd0, 2'd0, "R11");
      load_tbl(32'h0000_9000, 16'd7);
      run_case(8'd1, 2'd0, 2'd0, "R11");
      run_case(8'd0, 2'd0, 2'd0, "R11");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule